// File: doc/BRIEF.md
# SPI FIFO Status Flags and Receive DMA Request

This block tracks the occupancy of an SPI peripheral's receive and transmit FIFOs. From those counts it derives two status flags: receive-FIFO-empty and transmit-nearly-empty. It also drives the receive DMA request. The FIFO storage is not part of the block. Each FIFO appears only as an occupancy count, and pushes and pops update that count.

Three control bits are watched: SPI mode, FIFO mode and module enable. A change to any of them triggers a flush one cycle later. The flush empties both counts and reloads the flags. After power-on reset the flags read 0. After a flush they read 1 when FIFO mode is on and 0 when it is off. With FIFO mode and DMA both enabled, the DMA request is high whenever the receive FIFO holds data.

A receive pop is a data-register read. In 16-bit mode it needs the high and low halves read together. In 8-bit mode a read of the low half alone is enough.

Top module: `spi_fifo_flags`

## Requirements
- R1: After reset release, with all inputs low, the outputs rx_empty, tx_near_empty, flush and dma_req are 0, and rx_level and tx_level are 0.
- R2: If spi_mode, fifo_mode or enable differs from its value in the previous cycle, flush is 1 in the following cycle.
- R3: The flags are flag-live only after a flush with fifo_mode=1. Such a flush makes rx_empty=1 and tx_near_empty=1. A flush with fifo_mode=0 makes both flags 0, and they stay 0 until the next flush.
- R4: While flag-live, rx_empty is 1 when rx_level is 0 and 0 when rx_level is nonzero.
- R5: While flag-live, tx_near_empty is 1 when tx_level is at most TX_NEAR (2), and 0 otherwise.
- R6: dma_req is 1 exactly when dma_en=1, the flags are flag-live and rx_level is nonzero. It stays high until the receive FIFO empties.
- R7: With wide=1, a receive pop needs rd_high=1 and rd_low=1 in the same cycle. With wide=0, rd_low=1 alone pops. In both modes rd_high alone does not pop.
- R8: A push to a full FIFO (level = DEPTH = 4) is dropped. A pop from an empty FIFO is dropped. Levels never exceed DEPTH.
- R9: A push and a pop in the same cycle leave a non-empty FIFO's level unchanged. On an empty FIFO the push takes effect and the level becomes 1.
- R10: In the cycle where flush is 1, pushes and pops are discarded, and both levels read 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| spi_mode | input | 1 | SPI mode control bit |
| fifo_mode | input | 1 | FIFO mode enable |
| enable | input | 1 | Module enable |
| dma_en | input | 1 | Receive DMA enable |
| wide | input | 1 | 1 = 16-bit data, 0 = 8-bit data |
| rd_high | input | 1 | Read strobe, high data register |
| rd_low | input | 1 | Read strobe, low data register |
| rx_push | input | 1 | Receive FIFO push |
| tx_push | input | 1 | Transmit FIFO push |
| tx_pop | input | 1 | Transmit FIFO pop |
| rx_empty | output | 1 | Receive FIFO empty flag |
| tx_near_empty | output | 1 | Transmit FIFO nearly empty flag |
| flush | output | 1 | One-cycle flush pulse following a control change |
| dma_req | output | 1 | Receive DMA request |
| rx_level | output | 3 | Receive FIFO occupancy |
| tx_level | output | 3 | Transmit FIFO occupancy |

## Verification
A wrong registered copy of the control bits shows up in flush: a flush that fires with no cause, or that is missing one cycle after a change. The next cycle then shows stale levels or flags. A wrong occupancy count shows up on rx_level or tx_level in the cycle after the faulty push or pop. The same error also flips rx_empty, tx_near_empty or dma_req once the count crosses zero or the near-empty threshold. A wrong flag-live bit appears straight after a flush, as flags that disagree with fifo_mode.

// File: rtl/spi_fifo_flags.sv
module spi_fifo_flags #(
  parameter int DEPTH   = 4,
  parameter int TX_NEAR = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           spi_mode,
  input  logic                           fifo_mode,
  input  logic                           enable,
  input  logic                           dma_en,
  input  logic                           wide,
  input  logic                           rd_high,
  input  logic                           rd_low,
  input  logic                           rx_push,
  input  logic                           tx_push,
  input  logic                           tx_pop,
  output logic                           rx_empty,
  output logic                           tx_near_empty,
  output logic                           flush,
  output logic                           dma_req,
  output logic [$clog2(DEPTH+1)-1:0]     rx_level,
  output logic [$clog2(DEPTH+1)-1:0]     tx_level
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [LW-1:0] FULL_L = LW'(DEPTH);
  localparam logic [LW-1:0] NEAR_L = LW'(TX_NEAR);

  logic [2:0] ctl_q;
  logic       flush_q, live_q;
  logic       rx_pop_req, rx_pop_ok, rx_push_ok, tx_pop_ok, tx_push_ok;

  assign rx_pop_req = rd_low & (~wide | rd_high);
  assign rx_pop_ok  = rx_pop_req & (rx_level != '0);
  assign rx_push_ok = rx_push & ((rx_level != FULL_L) | rx_pop_ok);
  assign tx_pop_ok  = tx_pop & (tx_level != '0);
  assign tx_push_ok = tx_push & ((tx_level != FULL_L) | tx_pop_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      flush_q  <= 1'b0;
      live_q   <= 1'b0;
      rx_level <= '0;
      tx_level <= '0;
    end else begin
      ctl_q   <= {spi_mode, fifo_mode, enable};
      flush_q <= ({spi_mode, fifo_mode, enable} != ctl_q);
      if (flush_q) begin
        live_q   <= ctl_q[1];
        rx_level <= '0;
        tx_level <= '0;
      end else begin
        rx_level <= rx_level + LW'(rx_push_ok) - LW'(rx_pop_ok);
        tx_level <= tx_level + LW'(tx_push_ok) - LW'(tx_pop_ok);
      end
    end
  end

  assign flush         = flush_q;
  assign rx_empty      = live_q & (rx_level == '0);
  assign tx_near_empty = live_q & (tx_level <= NEAR_L);
  assign dma_req       = live_q & dma_en & (rx_level != '0);
endmodule

module spi_fifo_flags_chk #(
  parameter int DEPTH   = 4,
  parameter int TX_NEAR = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       spi_mode,
  input logic                       fifo_mode,
  input logic                       enable,
  input logic                       dma_en,
  input logic                       rx_empty,
  input logic                       tx_near_empty,
  input logic                       flush,
  input logic                       dma_req,
  input logic [$clog2(DEPTH+1)-1:0] rx_level,
  input logic [$clog2(DEPTH+1)-1:0] tx_level
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0; else armed <= 1'b1;

  AST_FLUSH_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$stable({spi_mode, fifo_mode, enable}) |=> flush); // R2
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (rx_level == 0) && (tx_level == 0)); // R10
  AST_EMPTY_MEANS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> rx_level == 0); // R4
  AST_NEAR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_near_empty |-> tx_level <= TX_NEAR); // R5
  AST_DMA_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> dma_en && !rx_empty && rx_level != 0); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level <= DEPTH) && (tx_level <= DEPTH)); // R8
endmodule

bind spi_fifo_flags spi_fifo_flags_chk #(.DEPTH(DEPTH), .TX_NEAR(TX_NEAR)) i_chk (
  .clk(clk), .rst_n(rst_n), .spi_mode(spi_mode), .fifo_mode(fifo_mode),
  .enable(enable), .dma_en(dma_en), .rx_empty(rx_empty),
  .tx_near_empty(tx_near_empty), .flush(flush), .dma_req(dma_req),
  .rx_level(rx_level), .tx_level(tx_level));

// File: tb/test_spi_fifo_flags.sv
module test_spi_fifo_flags;
  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_mode = 0, fifo_mode = 0, enable = 0, dma_en = 0, wide = 0;
  logic rd_high = 0, rd_low = 0, rx_push = 0, tx_push = 0, tx_pop = 0;
  logic rx_empty, tx_near_empty, flush, dma_req;
  logic [2:0] rx_level, tx_level;
  int vectors = 0, fails = 0;

  int m_rx = 0, m_tx = 0;
  logic [2:0] m_ctl = '0;
  logic m_flush = 0, m_live = 0;

  always #2 clk = ~clk;

  spi_fifo_flags i_spi_fifo_flags (.*);

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp(tag, "rx_level", int'(rx_level), m_rx);
    cmp(tag, "tx_level", int'(tx_level), m_tx);
    cmp(tag, "flush", int'(flush), int'(m_flush));
    cmp(tag, "rx_empty", int'(rx_empty), int'(m_live && m_rx == 0));
    cmp(tag, "tx_near_empty", int'(tx_near_empty), int'(m_live && m_tx <= 2));
    cmp(tag, "dma_req", int'(dma_req), int'(m_live && dma_en && m_rx != 0));
  endtask

  // advance one clock with current inputs, update the arithmetic model, check
  task automatic step(input string tag);
    logic [2:0] ctl;
    bit rpop, rpush, tpop, tpush;
    ctl = {spi_mode, fifo_mode, enable};
    rpop  = rd_low && (!wide || rd_high) && m_rx > 0;
    rpush = rx_push && (m_rx < 4 || rpop);
    tpop  = tx_pop && m_tx > 0;
    tpush = tx_push && (m_tx < 4 || tpop);
    if (m_flush) begin
      m_rx = 0; m_tx = 0; m_live = m_ctl[1];
    end else begin
      m_rx = m_rx + int'(rpush) - int'(rpop);
      m_tx = m_tx + int'(tpush) - int'(tpop);
    end
    m_flush = (ctl != m_ctl);
    m_ctl = ctl;
    @(posedge clk); #1;
    check_all(tag);
  endtask

  task automatic idle_inputs();
    rd_high = 0; rd_low = 0; rx_push = 0; tx_push = 0; tx_pop = 0;
  endtask

  task automatic fill(input int rx_n, input int tx_n);
    idle_inputs();
    while (m_rx > rx_n || m_tx > tx_n) begin
      rd_low = (m_rx > rx_n); wide = 0; tx_pop = (m_tx > tx_n);
      step("R8"); idle_inputs();
    end
    while (m_rx < rx_n || m_tx < tx_n) begin
      rx_push = (m_rx < rx_n); tx_push = (m_tx < tx_n);
      step("R8"); idle_inputs();
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1 check_all("R1");
    step("R1");

    // enter FIFO mode: flush, then live flags
    fifo_mode = 1; enable = 1; step("R2");
    step("R2"); step("R3");
    cmp("R3", "rx_empty after flush", int'(rx_empty), 1);
    cmp("R3", "tx_near after flush", int'(tx_near_empty), 1);

    // receive sweep: every level, every read/push combination, both DMA settings
    for (int d = 0; d < 2; d++)
      for (int lvl = 0; lvl <= 4; lvl++)
        for (int c = 0; c < 16; c++) begin
          dma_en = d[0];
          fill(lvl, 0);
          wide = c[0]; rd_high = c[1]; rd_low = c[2]; rx_push = c[3];
          step(c[3] ? "R9" : "R7");
          idle_inputs(); step("R6");
        end

    // DMA stays high while draining, drops at empty
    dma_en = 1; fill(4, 0);
    for (int k = 0; k < 5; k++) begin
      wide = 1; rd_high = 1; rd_low = 1; step("R6");
    end
    idle_inputs(); step("R4");

    // transmit sweep: every level, push/pop combination
    for (int lvl = 0; lvl <= 4; lvl++)
      for (int c = 0; c < 4; c++) begin
        fill(0, lvl);
        tx_push = c[0]; tx_pop = c[1];
        step(c == 3 ? "R9" : "R5");
        idle_inputs(); step("R5");
      end

    // pushes during flush cycle are discarded
    fill(3, 3);
    spi_mode = 1; step("R2");
    rx_push = 1; tx_push = 1; step("R10");
    idle_inputs(); step("R10");

    // leave FIFO mode: flags go to 0 and DMA drops
    fill(2, 1);
    fifo_mode = 0; step("R2"); step("R3"); step("R3");
    fill(3, 4); step("R3");

    // enable toggles, FIFO mode off then back on
    enable = 0; step("R2"); step("R3");
    enable = 1; fifo_mode = 1; step("R2"); step("R3");
    fill(1, 2); step("R6");

    // back-to-back control toggles
    for (int k = 0; k < 4; k++) begin
      spi_mode = ~spi_mode; rx_push = 1; step("R2");
    end
    idle_inputs(); step("R10"); step("R10");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule